// File: doc/BRIEF.md
# Sticky Fault Latch Register

This block collects fault indications from several sources into one 16-bit register whose bits, once set, stay set. Eight fault lines from outside the chip and three generated inside the chip set drive the low bits. A three-bit self-test result drives the top three bits. Bit 11 has no source, and bit 12 is reserved. Both always read zero. The whole register can be read at any time through a parallel read port.

A set bit cannot be cleared on its own. The only way to empty the register is a single clear command, which acts on all bits at once. The OR of all latched bits goes through an edge detector. When the register changes from empty to non-empty, the detector emits one single-cycle request pulse. That pulse raises the level-one interrupt in an interrupt controller. More faults latched while the register is already non-empty add no further pulse.

Top module: `fault_latch_top`

## Requirements
- R1: While `rst` is high at a clock edge, the register clears to 0x0000 and `irqPulse` is low. After `rst` falls, no pulse appears until a fault is latched.
- R2: `extFaultN[i]` (active low, i = 0..7) sampled low at a clock edge sets register bit i, which is visible on `faultReg` after that edge.
- R3: `intFaultN[j]` (active low, j = 0..2) sampled low at a clock edge sets register bit 8+j.
- R4: `bistFail[k]` (active high, k = 0..2) sampled high at a clock edge sets register bit 13+k.
- R5: Bits 11 and 12 of `faultReg` always read 0, even with every input asserted.
- R6: A set bit stays set after its input is released, for as long as no clear is applied.
- R7: `clrAll` high at a clock edge with no fault input asserted leaves `faultReg` at 0x0000.
- R8: A fault input asserted in the same cycle as `clrAll` leaves its bit set after the clear. The other bits are cleared.
- R9: `irqPulse` is high for exactly one cycle. That cycle is the first one in which `faultReg` is non-zero after being zero.
- R10: Latching another fault while the register is already non-zero produces no pulse. A clear that captures a simultaneous fault also produces no pulse.
- R11: After a clear empties the register, the next latched fault produces a new pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| extFaultN | input | 8 | Off-chip fault lines, active low, bits 0..7 |
| intFaultN | input | 3 | Chip-set fault lines, active low, bits 8..10 |
| bistFail | input | 3 | Self-test result, active high, bits 13..15 |
| clrAll | input | 1 | Clear the whole register |
| faultReg | output | 16 | Register contents |
| irqPulse | output | 1 | One-cycle level-one interrupt request |

## Verification
Some properties are checked on every cycle by assertions. Bits never drop without a clear. A clear loads exactly the faults present in that cycle. The two unsourced bits stay zero. A pulse never lasts two cycles, and it only appears when the OR goes from zero to one. Other behaviour can only be shown by the bench's scenarios. These are the mapping of each input line to its bit position and the polarity of each input group. They also cover the exact cycle of the pulse, and the absence of a pulse when a clear captures a fault or a second fault stacks onto a non-empty register.

// File: rtl/fault_latch_pkg.sv
package fault_latch_pkg;
  typedef struct packed {
    logic clear;
    logic capture;
  } flt_strobe_t;
endpackage

// File: rtl/fault_latch_ctrl.sv
module fault_latch_ctrl
  import fault_latch_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clrCmd,
  input  logic        anyFault,
  output flt_strobe_t strb,
  output logic        irqPulse
);
  logic sumN;
  logic sumNd;

  assign sumN = ~anyFault;

  always_ff @(posedge clk) begin
    if (rst) sumNd <= 1'b1;
    else     sumNd <= sumN;
  end

  always_comb begin
    strb.clear   = clrCmd & ~rst;
    strb.capture = ~rst;
  end

  // falling edge of the active-low summary
  assign irqPulse = sumNd & ~sumN;

  // R9
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    irqPulse |=> !irqPulse);
  // R9
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irqPulse |-> (anyFault && !$past(anyFault)));
  // R10
  no_repulse_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(anyFault) && anyFault) |-> !irqPulse);
endmodule

// File: rtl/fault_latch_dp.sv
module fault_latch_dp
  import fault_latch_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int EXT_N  = 8,
  parameter int INT_N  = 3,
  parameter int BIST_N = 3,
  parameter int RSVD   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EXT_N-1:0]  extFaultN,
  input  logic [INT_N-1:0]  intFaultN,
  input  logic [BIST_N-1:0] bistFail,
  input  flt_strobe_t       strb,
  output logic [WIDTH-1:0]  regQ,
  output logic              anyFault
);
  localparam int INT_LO  = EXT_N;
  localparam int SPARE_LO = EXT_N + INT_N;
  localparam int BIST_LO = WIDTH - BIST_N;

  logic [WIDTH-1:0] setVec;

  for (genvar b = 0; b < WIDTH; b++) begin : g_src
    if (b < INT_LO) begin : g_ext
      assign setVec[b] = ~extFaultN[b];
    end else if (b < SPARE_LO) begin : g_int
      assign setVec[b] = ~intFaultN[b-INT_LO];
    end else if (b >= BIST_LO) begin : g_bist
      assign setVec[b] = bistFail[b-BIST_LO];
    end else begin : g_tie
      assign setVec[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                regQ <= '0;
    else if (strb.clear)    regQ <= setVec;
    else if (strb.capture)  regQ <= regQ | setVec;
  end

  assign anyFault = |regQ;

  // R1
  reset_chk: assert property (@(posedge clk) rst |=> (regQ == '0));
  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.clear |=> ((regQ & $past(regQ)) == $past(regQ)));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    strb.clear |=> (regQ == $past(setVec)));
  // R5
  rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    (regQ[RSVD] == 1'b0) && (regQ[SPARE_LO] == 1'b0));
endmodule

// File: rtl/fault_latch_top.sv
module fault_latch_top
  import fault_latch_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int EXT_N  = 8,
  parameter int INT_N  = 3,
  parameter int BIST_N = 3,
  parameter int RSVD   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EXT_N-1:0]  extFaultN,
  input  logic [INT_N-1:0]  intFaultN,
  input  logic [BIST_N-1:0] bistFail,
  input  logic              clrAll,
  output logic [WIDTH-1:0]  faultReg,
  output logic              irqPulse
);
  flt_strobe_t strb;
  logic        anyFault;

  fault_latch_ctrl u_ctrl (
    .clk(clk), .rst(rst), .clrCmd(clrAll), .anyFault(anyFault),
    .strb(strb), .irqPulse(irqPulse)
  );

  fault_latch_dp #(
    .WIDTH(WIDTH), .EXT_N(EXT_N), .INT_N(INT_N), .BIST_N(BIST_N), .RSVD(RSVD)
  ) u_dp (
    .clk(clk), .rst(rst), .extFaultN(extFaultN), .intFaultN(intFaultN),
    .bistFail(bistFail), .strb(strb), .regQ(faultReg), .anyFault(anyFault)
  );
endmodule

// File: tb/sim_fault_latch_top.sv
module sim_fault_latch_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  extFaultN;
  logic [2:0]  intFaultN;
  logic [2:0]  bistFail;
  logic        clrAll;
  logic [15:0] faultReg;
  logic        irqPulse;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_latch_top u0 (
    .clk(clk), .rst(rst), .extFaultN(extFaultN), .intFaultN(intFaultN),
    .bistFail(bistFail), .clrAll(clrAll), .faultReg(faultReg), .irqPulse(irqPulse)
  );

  // {extFaultN, intFaultN, bistFail, clrAll, expected faultReg, expected irqPulse}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'hFF, 3'b111, 3'b000, 1'b0, 16'h0000, 1'b0}, // idle
    {8'hFE, 3'b111, 3'b000, 1'b0, 16'h0001, 1'b1}, // R2 R9 first fault
    {8'hFF, 3'b111, 3'b000, 1'b0, 16'h0001, 1'b0}, // R6 R9 sticky, pulse ends
    {8'h7F, 3'b111, 3'b000, 1'b0, 16'h0081, 1'b0}, // R2 R10 stacked fault
    {8'hFF, 3'b111, 3'b000, 1'b1, 16'h0000, 1'b0}, // R7 clear
    {8'hFF, 3'b110, 3'b000, 1'b0, 16'h0100, 1'b1}, // R3 R11 new pulse
    {8'hFF, 3'b011, 3'b000, 1'b0, 16'h0500, 1'b0}, // R3 R10
    {8'hFF, 3'b111, 3'b101, 1'b0, 16'hA500, 1'b0}, // R4
    {8'hEF, 3'b111, 3'b000, 1'b1, 16'h0010, 1'b0}, // R8 R10 clear captures
    {8'hFF, 3'b111, 3'b000, 1'b0, 16'h0010, 1'b0}, // R6
    {8'hFF, 3'b111, 3'b000, 1'b1, 16'h0000, 1'b0}, // R7
    {8'hFF, 3'b111, 3'b010, 1'b0, 16'h4000, 1'b1}, // R4 R11
    {8'hFF, 3'b111, 3'b000, 1'b1, 16'h0000, 1'b0}, // R7
    {8'hFF, 3'b111, 3'b000, 1'b0, 16'h0000, 1'b0}  // R7 stays empty
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    extFaultN = 8'hFF; intFaultN = 3'b111; bistFail = 3'b000; clrAll = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    step(); step();
    check("R1 reset reg", faultReg, 16'h0000);
    check("R1 reset pulse", {15'd0, irqPulse}, 16'd0);
    rst = 1'b0;
    step();
    check("R1 no pulse after reset", {15'd0, irqPulse}, 16'd0);

    for (int i = 0; i < NVEC; i++) begin
      {extFaultN, intFaultN, bistFail, clrAll} = VEC[i][31:17];
      step();
      check($sformatf("vec%0d reg", i), faultReg, VEC[i][16:1]);
      check($sformatf("vec%0d R9 pulse", i), {15'd0, irqPulse}, {15'd0, VEC[i][0]});
    end

    // R5: everything asserted, bits 11 and 12 stay zero
    extFaultN = 8'h00; intFaultN = 3'b000; bistFail = 3'b111;
    step();
    check("R5 all set", faultReg, 16'hE7FF);
    check("R9 all set pulse", {15'd0, irqPulse}, 16'd1);
    idle();
    step();
    check("R6 all held", faultReg, 16'hE7FF);

    // R1: reset from a loaded state, no pulse afterwards
    rst = 1'b1;
    step();
    check("R1 mid reset reg", faultReg, 16'h0000);
    check("R1 mid reset pulse", {15'd0, irqPulse}, 16'd0);
    rst = 1'b0;
    step();
    check("R1 post reset pulse", {15'd0, irqPulse}, 16'd0);

    // R9: pulse exactly one cycle on a held fault
    extFaultN = 8'hFD;
    step();
    check("R2 bit1", faultReg, 16'h0002);
    check("R9 pulse on", {15'd0, irqPulse}, 16'd1);
    step();
    check("R9 pulse off while held", {15'd0, irqPulse}, 16'd0);
    idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule